// File: doc/BRIEF.md
# Write-Through Cache with Word-Granular Valid Bits

A direct-mapped, write-through cache controller whose lines are divided into one-word subblocks, each carrying its own valid bit. A processor-side word port issues loads and stores. Stores never fetch the surrounding line. The word and the line tag are written into the array at once, and the same word is sent to memory on a write port. Loads return data only when both the tag matches and the addressed word's valid bit is set. Otherwise exactly that one word is fetched over a memory read port.

The processor holds a request (`req_i`, `we_i`, `addr_i`, `wdata_i`) until `ready_o` is high at a clock edge. Addresses are word addresses, split as word offset (low bits), line index, then tag (high bits). With the defaults, `addr_i[1:0]` selects the word, `addr_i[4:2]` the line and `addr_i[15:5]` is the tag. Memory ports use a request/acknowledge pair. The controller holds address and data stable until the acknowledge arrives.

Top module: `cache_wt_subblock`

## Requirements
- R1: After reset every valid bit is clear: the first load to any address issues a memory read, and `ready_o`, `mr_req_o` and `mw_req_o` are low while idle.
- R2: A load whose tag matches and whose word valid bit is set completes with `ready_o` high in the same cycle as the request, with no memory read, returning the cached word.
- R3: A load that misses fetches only the addressed word. `ready_o` rises in the cycle `mr_ack_i` is high, returning `mr_data_i`, and that word becomes valid. Other words of the line stay invalid.
- R4: A load miss with a tag mismatch replaces the line tag and leaves only the fetched word valid.
- R5: A store to a word whose tag matches and that is valid overwrites the word, which stays valid.
- R6: A store to a word whose tag matches but that is invalid writes the word and makes it valid, without reading memory.
- R7: A store with a tag mismatch replaces the tag, makes the stored word valid and invalidates every other word of the line.
- R8: Every store is sent on the memory write port with its address and data held stable until `mw_ack_i`. The processor is stalled (`ready_o` low) until that acknowledge.
- R9: A store never issues a memory read.
- R10: The memory read port holds its address stable until `mr_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Processor request, held until `ready_o` |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 16 | Word address |
| wdata_i | input | 32 | Store data |
| ready_o | output | 1 | Request completes this cycle |
| rdata_o | output | 32 | Load data, valid with `ready_o` |
| mw_req_o | output | 1 | Memory write request |
| mw_addr_o | output | 16 | Memory write address |
| mw_data_o | output | 32 | Memory write data |
| mw_ack_i | input | 1 | Memory write accepted |
| mr_req_o | output | 1 | Memory read request |
| mr_addr_o | output | 16 | Memory read address |
| mr_ack_i | input | 1 | Memory read data returned |
| mr_data_i | input | 32 | Memory read data |

## Verification
The hardest state to reach is a line whose tag matches a later access while some of its words are invalid. That state arises only after a store with a mismatched tag has wiped the siblings, or after a single-word fill. The stimulus builds it deliberately. It fills one word, stores to a neighbour under the same tag, then stores under a different tag to the same line and loads the siblings. Hits are told apart from misses by changing the bench memory behind the cache's back. A hit must return the stale cached word, and a miss must return the new memory value and show a read request.

// File: rtl/cache_wt_pkg.sv
package cache_wt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2
  } cache_st_e;
endpackage

// File: rtl/cache_tagv.sv
module cache_tagv #(
  parameter int LINES = 8,
  parameter int WORDS = 4,
  parameter int TAG_W = 11,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic [TAG_W-1:0] tag_o,
  output logic [WORDS-1:0] valid_o,
  input  logic             we_i,
  input  logic [TAG_W-1:0] wtag_i,
  input  logic [OFF_W-1:0] wword_i,
  input  logic             keep_i   // tag matched: keep sibling valid bits
);
  logic [TAG_W-1:0] tag_q   [LINES];
  logic [WORDS-1:0] valid_q [LINES];

  assign tag_o   = tag_q[idx_i];
  assign valid_o = valid_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]   <= '0;
        valid_q[i] <= '0;
      end
    end else if (we_i) begin
      tag_q[idx_i] <= wtag_i;
      if (keep_i) valid_q[idx_i][wword_i] <= 1'b1;
      else        valid_q[idx_i] <= WORDS'(1) << wword_i;
    end
  end
endmodule

// File: rtl/cache_data.sv
module cache_data #(
  parameter int ENTRIES = 32,
  parameter int DATA_W  = 32,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [ENTRIES];

  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_wt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  input  logic hit_i,
  input  logic mw_ack_i,
  input  logic mr_ack_i,
  output logic idle_o,
  output logic ready_o,
  output logic mw_req_o,
  output logic mr_req_o,
  output logic arr_we_o,
  output logic fill_o
);
  cache_st_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    ready_o  = 1'b0;
    mw_req_o = 1'b0;
    mr_req_o = 1'b0;
    arr_we_o = 1'b0;
    fill_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_i && we_i) begin
          arr_we_o = 1'b1;  // allocate without fetch
          st_d     = ST_WR;
        end else if (req_i && hit_i) begin
          ready_o = 1'b1;
        end else if (req_i) begin
          st_d = ST_RD;
        end
      end
      ST_WR: begin
        mw_req_o = 1'b1;
        if (mw_ack_i) begin
          ready_o = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_RD: begin
        mr_req_o = 1'b1;
        if (mr_ack_i) begin
          arr_we_o = 1'b1;
          fill_o   = 1'b1;
          ready_o  = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign idle_o = (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/cache_wt_subblock.sv
module cache_wt_subblock #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  localparam int OFF_W = $clog2(WORDS),
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mw_req_o,
  output logic [ADDR_W-1:0] mw_addr_o,
  output logic [DATA_W-1:0] mw_data_o,
  input  logic              mw_ack_i,
  output logic              mr_req_o,
  output logic [ADDR_W-1:0] mr_addr_o,
  input  logic              mr_ack_i,
  input  logic [DATA_W-1:0] mr_data_i
);
  logic [ADDR_W-1:0] lat_addr_q, cur_addr;
  logic [DATA_W-1:0] lat_data_q;
  logic              idle, arr_we, fill, hit, tag_eq;
  logic [TAG_W-1:0]  cur_tag, line_tag;
  logic [IDX_W-1:0]  cur_idx;
  logic [OFF_W-1:0]  cur_word;
  logic [WORDS-1:0]  line_valid;
  logic [DATA_W-1:0] arr_rdata, arr_wdata;

  assign cur_addr = idle ? addr_i : lat_addr_q;
  assign cur_word = cur_addr[OFF_W-1:0];
  assign cur_idx  = cur_addr[OFF_W +: IDX_W];
  assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_addr_q <= '0;
      lat_data_q <= '0;
    end else if (idle && req_i) begin
      lat_addr_q <= addr_i;
      lat_data_q <= wdata_i;
    end
  end

  cache_tagv #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) i_tagv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (cur_idx),
    .tag_o   (line_tag),
    .valid_o (line_valid),
    .we_i    (arr_we),
    .wtag_i  (cur_tag),
    .wword_i (cur_word),
    .keep_i  (tag_eq)
  );

  assign tag_eq    = (line_tag == cur_tag);
  assign hit       = tag_eq && line_valid[cur_word];
  assign arr_wdata = fill ? mr_data_i : wdata_i;

  cache_data #(.ENTRIES(LINES*WORDS), .DATA_W(DATA_W)) i_data (
    .clk_i   (clk_i),
    .addr_i  ({cur_idx, cur_word}),
    .we_i    (arr_we),
    .wdata_i (arr_wdata),
    .rdata_o (arr_rdata)
  );

  cache_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .hit_i    (hit),
    .mw_ack_i (mw_ack_i),
    .mr_ack_i (mr_ack_i),
    .idle_o   (idle),
    .ready_o  (ready_o),
    .mw_req_o (mw_req_o),
    .mr_req_o (mr_req_o),
    .arr_we_o (arr_we),
    .fill_o   (fill)
  );

  assign rdata_o   = fill ? mr_data_i : arr_rdata;
  assign mw_addr_o = lat_addr_q;
  assign mw_data_o = lat_data_q;
  assign mr_addr_o = lat_addr_q;
endmodule

// File: rtl/cache_wt_chk.sv
module cache_wt_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              ready_o,
  input logic              mw_req_o,
  input logic [ADDR_W-1:0] mw_addr_o,
  input logic [DATA_W-1:0] mw_data_o,
  input logic              mw_ack_i,
  input logic              mr_req_o,
  input logic [ADDR_W-1:0] mr_addr_o,
  input logic              mr_ack_i
);
  a_r8_store_done_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && ready_o) |-> mw_ack_i);

  a_r8_mw_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mw_req_o && !mw_ack_i) |=> (mw_req_o && $stable(mw_addr_o) && $stable(mw_data_o)));

  a_r9_no_read_on_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mw_req_o |-> !mr_req_o);

  a_r10_mr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr_req_o && !mr_ack_i) |=> (mr_req_o && $stable(mr_addr_o)));

  a_r3_fill_done_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr_req_o && ready_o) |-> mr_ack_i);

  a_r3_no_fill_done_without_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr_req_o && !mr_ack_i) |-> !ready_o);
endmodule

bind cache_wt_subblock cache_wt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_cache_wt_subblock.sv
module test_cache_wt_subblock;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          ready_o, mw_req_o, mr_req_o;
  logic [DW-1:0] rdata_o, mw_data_o;
  logic [AW-1:0] mw_addr_o, mr_addr_o;
  logic          mw_ack_i = 1'b0, mr_ack_i = 1'b0;
  logic [DW-1:0] mr_data_i = '0;

  always #5 clk_i = ~clk_i;

  cache_wt_subblock i_cache_wt_subblock (.*);

  int n_chk = 0, n_fail = 0;
  int rd_lat = 2, wr_lat = 1;
  logic [DW-1:0] mem [logic [AW-1:0]];

  typedef struct {
    logic          is_wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] exp;
    logic          exp_miss;
    string         req;
  } item_t;
  item_t sb_q[$];

  function automatic logic [DW-1:0] memrd(logic [AW-1:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'hC0DE_0000 | DW'(a);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory read responder
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk_i); #2;
      if (mr_ack_i) begin mr_ack_i = 1'b0; cnt = 0; end
      else if (mr_req_o) begin
        cnt++;
        if (cnt >= rd_lat) begin mr_ack_i = 1'b1; mr_data_i = memrd(mr_addr_o); end
      end
    end
  end

  // memory write responder
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk_i); #2;
      if (mw_ack_i) begin mw_ack_i = 1'b0; cnt = 0; end
      else if (mw_req_o) begin
        cnt++;
        if (cnt >= wr_lat) begin mw_ack_i = 1'b1; mem[mw_addr_o] = mw_data_o; end
      end
    end
  end

  // monitor
  initial begin
    logic seen = 1'b0;
    forever begin
      @(negedge clk_i);
      if (mr_req_o) seen = 1'b1;
      if (req_i && ready_o) begin
        item_t it;
        if (sb_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL scoreboard: actual unexpected completion expected none");
        end else begin
          it = sb_q.pop_front();
          check({it.req, " miss"}, DW'(seen), DW'(it.exp_miss));
          if (!it.is_wr) check({it.req, " data"}, rdata_o, it.exp);
        end
        seen = 1'b0;
      end
    end
  end

  task automatic xact(logic wr, logic [AW-1:0] a, logic [DW-1:0] d,
                      logic [DW-1:0] exp, logic miss, string req, output int cyc);
    item_t it;
    it.is_wr = wr; it.addr = a; it.exp = exp; it.exp_miss = miss; it.req = req;
    sb_q.push_back(it);
    @(posedge clk_i); #1;
    req_i = 1'b1; we_i = wr; addr_i = a; wdata_i = d;
    cyc = 0;
    do begin @(negedge clk_i); cyc++; end while (!ready_o);
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] exp, logic miss, string req);
    int c;
    xact(1'b0, a, '0, exp, miss, req, c);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, string req);
    int c;
    xact(1'b1, a, d, '0, 1'b0, req, c);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 idle outputs after reset
    check("R1 ready", DW'(ready_o), 0);
    check("R1 mr_req", DW'(mr_req_o), 0);
    check("R1 mw_req", DW'(mw_req_o), 0);

    // R1/R3: cold miss, single word fetched
    rd(16'h0040, memrd(16'h0040), 1'b1, "R1 R3 cold read");
    // R2: hit returns cached word even after memory changes
    mem[16'h0040] = 32'hDEAD_0040;
    rd(16'h0040, 32'hC0DE_0040, 1'b0, "R2 hit");
    // R3: sibling not filled by previous miss
    rd(16'h0041, memrd(16'h0041), 1'b1, "R3 sibling miss");
    // R6/R9: store to invalid word under matching tag
    wr(16'h0042, 32'h1111_1111, "R6 R9 store invalid");
    check("R8 write-through", memrd(16'h0042), 32'h1111_1111);
    mem[16'h0042] = 32'hBAD0_0042;
    rd(16'h0042, 32'h1111_1111, 1'b0, "R6 hit after store");
    // R5: store over valid word
    wr(16'h0040, 32'h2222_2222, "R5 store valid");
    mem[16'h0040] = 32'hBAD0_0040;
    rd(16'h0040, 32'h2222_2222, 1'b0, "R5 hit after store");
    mem[16'h0040] = 32'h2222_2222;
    // R7: store with tag mismatch on the same line
    wr(16'h0061, 32'h3333_3333, "R7 store mismatch");
    mem[16'h0061] = 32'hBAD0_0061;
    rd(16'h0061, 32'h3333_3333, 1'b0, "R7 stored word valid");
    rd(16'h0060, memrd(16'h0060), 1'b1, "R7 sibling invalidated");
    rd(16'h0042, 32'hBAD0_0042, 1'b1, "R7 old tag gone");
    // R4: read miss with mismatch replaced tag, siblings cleared
    rd(16'h0061, 32'hBAD0_0061, 1'b1, "R4 prior tag replaced");
    rd(16'h0060, memrd(16'h0060), 1'b1, "R4 sibling invalid after fill");
    // other line, different latencies
    rd_lat = 5;
    rd(16'h001F, memrd(16'h001F), 1'b1, "R3 long latency miss");
    rd(16'h001F, memrd(16'h001F), 1'b0, "R2 hit other line");
    // R8: stall while write port busy
    wr_lat = 4;
    xact(1'b1, 16'h001C, 32'h4444_4444, '0, 1'b0, "R8 slow store", c);
    n_chk++;
    if (c < wr_lat + 1 || c > wr_lat + 2) begin
      n_fail++;
      $display("FAIL R8 stall cycles: actual %0d expected %0d", c, wr_lat + 1);
    end
    check("R8 memory updated", memrd(16'h001C), 32'h4444_4444);
    rd(16'h001C, 32'h4444_4444, 1'b0, "R6 store then hit");
    check("R9 scoreboard drained", DW'(sb_q.size()), 0);

    repeat (3) @(posedge clk_i);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule